// File: doc/BRIEF.md
# Programmable Baud Rate Prescaler

This block divides the system clock down to the bit-rate tick of a serial port. A 12-bit divisor is loaded through a byte-wide write port as two registers: a high register that holds divisor bits 11:8, and a low register that holds bits 7:0. The high register is only a staging area. Software writes it first, and it has no effect on the running rate. Writing the low register commits the staged high nibble together with the new low byte as the active divisor. In the same cycle it reloads the down-counter, so the new rate starts at once and any partly elapsed period is discarded.

The counter runs from the active divisor down to zero. It raises `tick` for one clock in the cycle in which it reaches zero, then reloads. The tick period is therefore divisor+1 clocks, and a divisor of zero gives a tick on every clock. Both registers can be read back at all times, and the unused upper bits of the high register always read as zero.

The counter is a two-state machine. State `ST_FIRE` drives `tick` high. State `ST_COUNT` counts down with `tick` low. The transitions are:
- FIRE→FIRE (reload value zero)
- FIRE→COUNT (reload value nonzero)
- COUNT→COUNT (count above one, or a low write with a nonzero value)
- COUNT→FIRE (count reaches one, or a low write with a zero value)

Top module: `bdiv_prescaler`

## Requirements
- R1: After reset both readbacks are 0x00 and, with the divisor at zero, `tick` is high on every clock.
- R2: A write with `wr_en`=1 and `wr_sel`=0 stores `wr_data` in the low register, and `rd_lo` shows it from the next cycle.
- R3: A write with `wr_en`=1 and `wr_sel`=1 stores `wr_data[3:0]` in the high register. `rd_hi` then reads {4'b0000, wr_data[3:0]}: written bits 7:4 are ignored and read as zero.
- R4: A high-register write alone does not change the tick timing or `rd_lo`. The staged nibble only takes effect at the next low write.
- R5: A low write sampled at clock edge k makes the active divisor D = {high register, wr_data} and reloads the counter. The first tick is high in the cycle that follows edge k+D.
- R6: With no writes, consecutive ticks are exactly D+1 clocks apart, and each tick lasts one cycle when D>0.
- R7: With D=0, `tick` is high on every cycle.
- R8: A low write aborts the count in progress, including a write in the very cycle of a tick. Timing then restarts from the write as in R5.
- R9: With `wr_en`=0, neither register and neither readback changes, whatever `wr_sel` and `wr_data` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = low byte, 1 = high nibble |
| wr_data | input | 8 | Write data |
| tick | output | 1 | One-cycle baud tick |
| rd_lo | output | 8 | Low register readback |
| rd_hi | output | 8 | High register readback, bits 7:4 zero |

## Verification
The two functions that can meet in one cycle are the counter's own reload at zero and a reload forced by a low-register write. The bench watches for `tick` at the falling edge and drives a low write into that same cycle. It then checks that the new divisor, not the old one, sets the next spacing. A high write placed mid-count is judged by the same per-clock comparison to leave the old period intact. Every clock compares `tick` and both readbacks against a behavioural integer model.

// File: rtl/bdiv_pkg.sv
package bdiv_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DIV_W  = 12;

    typedef enum logic [0:0] {
        ST_FIRE  = 1'b0,
        ST_COUNT = 1'b1
    } bdiv_state_e;
endpackage

// File: rtl/bdiv_regs.sv
module bdiv_regs #(
    parameter int unsigned BYTE_W = bdiv_pkg::BYTE_W,
    parameter int unsigned DIV_W  = bdiv_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              commit,
    output logic [DIV_W-1:0]  commit_val,
    output logic [DIV_W-1:0]  active_div,
    output logic [BYTE_W-1:0] rd_lo,
    output logic [BYTE_W-1:0] rd_hi
);
    localparam int unsigned HI_W = DIV_W - BYTE_W;

    logic [HI_W-1:0]   stage_hi_q;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_wr;

    assign hi_wr      = wr_en && wr_sel;
    assign commit     = wr_en && !wr_sel;
    assign commit_val = {stage_hi_q, wr_data};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_hi_q <= '0;
            lo_q       <= '0;
            active_div <= '0;
        end else begin
            if (hi_wr) begin
                stage_hi_q <= wr_data[HI_W-1:0];
            end
            if (commit) begin
                lo_q       <= wr_data;
                active_div <= commit_val;
            end
        end
    end

    assign rd_lo = lo_q;

    generate
        if (HI_W < BYTE_W) begin : g_pad
            assign rd_hi = {{(BYTE_W - HI_W){1'b0}}, stage_hi_q};
        end else begin : g_full
            assign rd_hi = stage_hi_q[BYTE_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/bdiv_counter.sv
module bdiv_counter #(
    parameter int unsigned DIV_W = bdiv_pkg::DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] load_val,
    input  logic [DIV_W-1:0] active_div,
    output logic             tick
);
    import bdiv_pkg::*;

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    bdiv_state_e      state_q, state_d;
    logic [DIV_W-1:0] cnt_q, cnt_d;
    logic [DIV_W-1:0] reload_v;

    assign reload_v = load ? load_val : active_div;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FIRE: begin
                cnt_d   = reload_v;
                state_d = (reload_v == '0) ? ST_FIRE : ST_COUNT;
            end
            ST_COUNT: begin
                if (load) begin
                    cnt_d   = load_val;
                    state_d = (load_val == '0) ? ST_FIRE : ST_COUNT;
                end else if (cnt_q == ONE) begin
                    cnt_d   = '0;
                    state_d = ST_FIRE;
                end else begin
                    cnt_d   = cnt_q - ONE;
                    state_d = ST_COUNT;
                end
            end
            default: begin
                cnt_d   = '0;
                state_d = ST_FIRE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FIRE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        tick = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/bdiv_prescaler.sv
module bdiv_prescaler #(
    parameter int unsigned BYTE_W = bdiv_pkg::BYTE_W,
    parameter int unsigned DIV_W  = bdiv_pkg::DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick,
    output logic [BYTE_W-1:0] rd_lo,
    output logic [BYTE_W-1:0] rd_hi
);
    logic             commit;
    logic [DIV_W-1:0] commit_val;
    logic [DIV_W-1:0] active_div;

    bdiv_regs #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .commit     (commit),
        .commit_val (commit_val),
        .active_div (active_div),
        .rd_lo      (rd_lo),
        .rd_hi      (rd_hi)
    );

    bdiv_counter #(.DIV_W(DIV_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (commit),
        .load_val   (commit_val),
        .active_div (active_div),
        .tick       (tick)
    );
endmodule

// File: rtl/bdiv_prescaler_chk.sv
module bdiv_prescaler_chk #(
    parameter int unsigned BYTE_W = bdiv_pkg::BYTE_W,
    parameter int unsigned DIV_W  = bdiv_pkg::DIV_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic              tick,
    input logic [BYTE_W-1:0] rd_lo,
    input logic [BYTE_W-1:0] rd_hi,
    input logic [DIV_W-1:0]  active_div
);
    localparam int unsigned HI_W = DIV_W - BYTE_W;

    logic lo_wr;
    assign lo_wr = wr_en && !wr_sel;

    // R2
    lo_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (rd_lo == $past(wr_data)));

    // R3
    hi_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi >> HI_W) == '0);

    // R4
    hi_staged_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> ($stable(active_div) && $stable(rd_lo)));

    // R5
    lo_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> (tick == ($past({rd_hi[HI_W-1:0], wr_data}) == '0)));

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !lo_wr && (active_div != '0)) |=> !tick);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rd_lo) && $stable(rd_hi)));
endmodule

bind bdiv_prescaler bdiv_prescaler_chk #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .tick       (tick),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .active_div (active_div)
);

// File: tb/tb_bdiv_prescaler.sv
`timescale 1ns/1ps
module tb_bdiv_prescaler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick;
    logic [7:0] rd_lo, rd_hi;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model
    int m_stage = 0, m_lo = 0, m_active = 0, m_cnt = 0;

    always #2 clk = ~clk;

    bdiv_prescaler dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .tick(tick), .rd_lo(rd_lo), .rd_hi(rd_hi)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stage = 0; m_lo = 0; m_active = 0; m_cnt = 0;
        end else if (wr_en && !wr_sel) begin
            m_lo = int'(wr_data);
            m_active = m_stage * 256 + m_lo;
            m_cnt = m_active;
        end else begin
            if (wr_en && wr_sel) m_stage = int'(wr_data) % 16;
            if (m_cnt == 0) m_cnt = m_active;
            else m_cnt = m_cnt - 1;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, int'(tick), (m_cnt == 0) ? 1 : 0, "tick");
            check(cur_req, int'(rd_lo), m_lo, "rd_lo");
            check(cur_req, int'(rd_hi), m_stage, "rd_hi");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #100000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        @(negedge clk);
        check("R1", int'(rd_lo), 0, "reset rd_lo");
        check("R1", int'(rd_hi), 0, "reset rd_hi");
        check("R7", int'(tick), 1, "reset tick");
        idle(6);

        cur_req = "R3";
        wr(1'b1, 8'hF3);
        check("R3", int'(rd_hi), 8'h03, "reserved bits dropped");
        cur_req = "R4";
        idle(8);

        cur_req = "R5";
        wr(1'b0, 8'h02);
        check("R2", int'(rd_lo), 8'h02, "lo readback");
        cur_req = "R6";
        idle(1600);

        cur_req = "R4";
        wr(1'b1, 8'h00);
        idle(20);
        cur_req = "R6";
        wr(1'b0, 8'h04);
        idle(30);

        cur_req = "R8";
        idle(2);
        wr(1'b0, 8'h06);
        idle(25);

        // low write landing in the tick cycle
        cur_req = "R8";
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            while (!tick) @(negedge clk);
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'(3 + k);
            @(negedge clk);
            wr_en = 1'b0;
            idle(12);
        end

        cur_req = "R9";
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wr_en = 1'b0; wr_sel = i[0]; wr_data = 8'(i * 37 + 5);
        end
        check("R9", int'(rd_lo), 6, "lo held");
        check("R9", int'(rd_hi), 0, "hi held");

        cur_req = "R7";
        wr(1'b0, 8'h00);
        idle(10);

        cur_req = "R5";
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            wr_en = ((i % 3) == 0);
            wr_sel = ((i % 7) == 0);
            wr_data = 8'((i * 53 + 11) % 256) & ((i % 7) == 0 ? 8'h00 : 8'h0F);
        end
        idle(40);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule